// File: doc/BRIEF.md
# I2C Target with 256-Entry Register Map

This block is an I2C target that gives a bus controller access to a bank of 256 eight-bit registers. Everything runs from one fast system clock. The SCL and SDA inputs are oversampled through a two-stage synchronizer. Edges, START and STOP are detected from the sampled levels and used as enables. No bus signal is ever used as a clock.

The target answers to the fixed 7-bit address 0x50. In a write transfer, the first byte after the address loads an internal register pointer, and every later byte is stored at the pointer. In a read transfer, the target shifts out the register at the pointer. The pointer advances by one after each data byte in either direction, so bursts are possible. A repeated START keeps the pointer, so the usual sequence works: write the pointer, issue a repeated START, then read.

SDA is split into a sampled input and an output-enable. The target only ever pulls the line low or releases it. It never drives a one.

Top module: `i2c_regbank_target`

## Requirements
- R1: After reset, the target releases SDA (sda_oe_o = 0), and every register and the pointer are zero.
- R2: A START (SDA falling while SCL is high) restarts address reception at bit 0 at any moment, even in the middle of a byte. A STOP (SDA rising while SCL is high) returns the target to idle.
- R3: An address byte whose upper seven bits are 0x50 is acknowledged by pulling SDA low through the ninth SCL pulse. Any other address gets no acknowledge, and the bytes that follow it are neither acknowledged nor stored.
- R4: In a write transfer (address byte bit 0 = 0), the first byte loads the pointer and each later byte is written to the register at the pointer. Every one of these bytes is acknowledged.
- R5: The pointer increases by one after each data byte written or read, wrapping from 255 to 0. Its value carries over from one transfer to the next.
- R6: In a read transfer (address byte bit 0 = 1), the target sends the register at the pointer, most significant bit first. A repeated START does not change the pointer.
- R7: The target changes its SDA output only while SCL is low, and it only pulls the line low or releases it.
- R8: After each byte read, the target samples the controller's acknowledge. On an acknowledge it sends the next register. On a NACK it releases SDA and stays released until the next START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low local reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 = pull SDA low, 0 = release SDA to high impedance |

## Verification
Every one of the 128 possible addresses is offered in turn. This shows that only 0x50 is acknowledged, including against its one-bit neighbours. A single burst writes all 256 registers with an arithmetic pattern that gives each address a distinct value. A full-length read then starts at the middle of the map, so any address aliasing, dropped pointer step or missed wrap shows up as a wrong byte. Shorter cases cover:
- bursts across the 255-to-0 boundary in both directions;
- a START cut into a half-sent address byte;
- an extra clock pulse after a NACK, where the line must stay released;
- bytes sent after a foreign address, which must leave the addressed register unchanged.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
package i2c_tgt_pkg;

    localparam int DATA_W = 8;
    localparam int PTR_W  = 8;
    localparam int CNT_W  = $clog2(DATA_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } tgt_state_e;

    typedef struct packed {
        tgt_state_e         state;
        logic [CNT_W-1:0]   bit_cnt;
        logic [DATA_W-1:0]  shift;
        logic               is_read;
        logic [PTR_W-1:0]   ptr;
        logic               want_ptr;
        logic               ctl_ack;
        logic               pull;
    } tgt_regs_t;

endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl_o,
    output logic sda_lvl_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic [STAGES-1:0] scl_pipe_d, scl_pipe_q;
    logic [STAGES-1:0] sda_pipe_d, sda_pipe_q;
    logic              scl_prev_d, scl_prev_q;
    logic              sda_prev_d, sda_prev_q;

    always_comb begin
        scl_pipe_d = {scl_pipe_q[STAGES-2:0], scl_i};
        sda_pipe_d = {sda_pipe_q[STAGES-2:0], sda_i};
        scl_prev_d = scl_pipe_q[STAGES-1];
        sda_prev_d = sda_pipe_q[STAGES-1];
    end

    // the bus idles high, so the pipeline resets to ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_pipe_q <= scl_pipe_d;
            sda_pipe_q <= sda_pipe_d;
            scl_prev_q <= scl_prev_d;
            sda_prev_q <= sda_prev_d;
        end
    end

    assign scl_lvl_o  = scl_pipe_q[STAGES-1];
    assign sda_lvl_o  = sda_pipe_q[STAGES-1];
    assign scl_rise_o = scl_lvl_o & ~scl_prev_q;
    assign scl_fall_o = ~scl_lvl_o & scl_prev_q;
    assign start_o    = scl_lvl_o & scl_prev_q & sda_prev_q & ~sda_lvl_o;
    assign stop_o     = scl_lvl_o & scl_prev_q & ~sda_prev_q & sda_lvl_o;

endmodule

// File: rtl/i2c_reg_bank.sv
`timescale 1ns/1ps
module i2c_reg_bank #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we_i) begin
            mem_d[waddr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata_o = mem_q[raddr_i];

    // R4
    store_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));

endmodule

// File: rtl/i2c_tgt_fsm.sv
`timescale 1ns/1ps
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl_i,
    input  logic              sda_lvl_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [PTR_W-1:0]  rd_addr_o,
    output logic              wr_en_o,
    output logic [PTR_W-1:0]  wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              pull_o
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

    tgt_regs_t r_d, r_q;
    logic      wr_en_d;

    always_comb begin
        r_d     = r_q;
        wr_en_d = 1'b0;
        if (stop_i) begin
            r_d.state = ST_IDLE;
            r_d.pull  = 1'b0;
        end else if (start_i) begin
            r_d.state   = ST_ADDR;
            r_d.bit_cnt = '0;
            r_d.pull    = 1'b0;
        end else begin
            unique case (r_q.state)
                ST_ADDR: begin
                    if (scl_rise_i && r_q.bit_cnt < FULL) begin
                        r_d.shift   = {r_q.shift[DATA_W-2:0], sda_lvl_i};
                        r_d.bit_cnt = r_q.bit_cnt + 1'b1;
                    end else if (scl_fall_i && r_q.bit_cnt == FULL) begin
                        if (r_q.shift[DATA_W-1:1] == DEV_ADDR) begin
                            r_d.state   = ST_ADDR_ACK;
                            r_d.is_read = r_q.shift[0];
                            r_d.pull    = 1'b1;
                        end else begin
                            r_d.state = ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall_i) begin
                        r_d.bit_cnt = '0;
                        if (r_q.is_read) begin
                            r_d.state = ST_TX;
                            r_d.shift = rd_data_i;
                            r_d.pull  = ~rd_data_i[DATA_W-1];
                        end else begin
                            r_d.state    = ST_RX;
                            r_d.want_ptr = 1'b1;
                            r_d.pull     = 1'b0;
                        end
                    end
                end
                ST_RX: begin
                    if (scl_rise_i && r_q.bit_cnt < FULL) begin
                        r_d.shift   = {r_q.shift[DATA_W-2:0], sda_lvl_i};
                        r_d.bit_cnt = r_q.bit_cnt + 1'b1;
                    end else if (scl_fall_i && r_q.bit_cnt == FULL) begin
                        r_d.state = ST_RX_ACK;
                        r_d.pull  = 1'b1;
                        if (r_q.want_ptr) begin
                            r_d.ptr      = r_q.shift;
                            r_d.want_ptr = 1'b0;
                        end else begin
                            wr_en_d = 1'b1;
                            r_d.ptr = r_q.ptr + 1'b1;
                        end
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall_i) begin
                        r_d.state   = ST_RX;
                        r_d.bit_cnt = '0;
                        r_d.pull    = 1'b0;
                    end
                end
                ST_TX: begin
                    if (scl_rise_i && r_q.bit_cnt < FULL) begin
                        r_d.bit_cnt = r_q.bit_cnt + 1'b1;
                    end else if (scl_fall_i) begin
                        if (r_q.bit_cnt == FULL) begin
                            r_d.state = ST_TX_ACK;
                            r_d.pull  = 1'b0;
                            r_d.ptr   = r_q.ptr + 1'b1;
                        end else begin
                            r_d.shift = {r_q.shift[DATA_W-2:0], 1'b0};
                            r_d.pull  = ~r_q.shift[DATA_W-2];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise_i) begin
                        r_d.ctl_ack = ~sda_lvl_i;
                    end else if (scl_fall_i) begin
                        if (r_q.ctl_ack) begin
                            r_d.state   = ST_TX;
                            r_d.bit_cnt = '0;
                            r_d.shift   = rd_data_i;
                            r_d.pull    = ~rd_data_i[DATA_W-1];
                        end else begin
                            r_d.state = ST_IDLE;
                            r_d.pull  = 1'b0;
                        end
                    end
                end
                default: begin
                    r_d.pull = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_addr_o = r_q.ptr;
    assign wr_en_o   = wr_en_d;
    assign wr_addr_o = r_q.ptr;
    assign wr_data_o = r_q.shift;
    assign pull_o    = r_q.pull;

    // R7
    pull_on_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.pull) |-> !$past(scl_lvl_i));

    // R3
    ack_own_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(r_q.pull) && r_q.state == ST_ADDR_ACK) |-> r_q.shift[DATA_W-1:1] == DEV_ADDR);

    // R5
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> r_q.ptr == PTR_W'($past(r_q.ptr) + 1'b1));

    // R2
    start_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (r_q.state == ST_ADDR && r_q.bit_cnt == '0 && !r_q.pull));

    // R8
    nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_TX_ACK && scl_fall_i && !r_q.ctl_ack && !start_i && !stop_i)
        |=> (r_q.state == ST_IDLE && !r_q.pull));

    // R2
    always @(posedge clk) begin
        if (rst_n) begin
            bit_cnt_range_chk: assert (r_q.bit_cnt <= FULL);
        end
    end

endmodule

// File: rtl/i2c_regbank_target.sv
`timescale 1ns/1ps
module i2c_regbank_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o
);

    logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic [PTR_W-1:0]  rd_addr, wr_addr;
    logic [DATA_W-1:0] rd_data, wr_data;
    logic              wr_en;

    i2c_line_sync #(
        .STAGES     (SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_lvl_o  (scl_lvl),
        .sda_lvl_o  (sda_lvl),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    i2c_tgt_fsm #(
        .DEV_ADDR   (DEV_ADDR)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_lvl_i  (scl_lvl),
        .sda_lvl_i  (sda_lvl),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_det),
        .stop_i     (stop_det),
        .rd_data_i  (rd_data),
        .rd_addr_o  (rd_addr),
        .wr_en_o    (wr_en),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data),
        .pull_o     (sda_oe_o)
    );

    i2c_reg_bank #(
        .ADDR_W     (PTR_W),
        .DATA_W     (DATA_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (wr_en),
        .waddr_i    (wr_addr),
        .wdata_i    (wr_data),
        .raddr_i    (rd_addr),
        .rdata_o    (rd_data)
    );

endmodule

// File: tb/i2c_regbank_target_tb_top.sv
`timescale 1ns/1ps
module i2c_regbank_target_tb_top;

    localparam int QTR      = 6;
    localparam int WD_LIMIT = 195000;
    localparam logic [6:0] OWN = 7'h50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_bus;

    int n_chk = 0;
    int n_fail = 0;
    int r7_viol = 0;
    bit done = 1'b0;
    logic [7:0] exp_mem [256];

    assign sda_bus = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    i2c_regbank_target dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .sda_oe_o (sda_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // R7: the target output may only move while the controller holds SCL low
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && sda_oe !== oe_prev && scl_m) r7_viol++;
        oe_prev <= sda_oe;
    end

    task automatic q_wait;
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; q_wait;
        scl_m = 1'b1; q_wait; q_wait;
        scl_m = 1'b0; q_wait;
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; q_wait;
        scl_m = 1'b1; q_wait;
        b = sda_bus; q_wait;
        scl_m = 1'b0; q_wait;
    endtask

    task automatic bus_start;
        sda_m = 1'b1; q_wait;
        scl_m = 1'b1; q_wait;
        sda_m = 1'b0; q_wait;
        scl_m = 1'b0; q_wait;
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; q_wait;
        scl_m = 1'b1; q_wait;
        sda_m = 1'b1; q_wait;
    endtask

    task automatic byte_out(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(b);
        acked = ~b;
    endtask

    task automatic byte_in(input logic give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            v[i] = b;
        end
        bit_out(~give_ack);
    endtask

    initial begin
        logic ack;
        logic [7:0] v;
        logic b;
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(sda_oe == 1'b0, "R1 released after reset", sda_oe, 0);

        // R1: register 0 reads as zero through a read with pointer at reset value
        bus_start;
        byte_out({OWN, 1'b1}, ack);
        chk(ack, "R3 own address read acked", ack, 1);
        byte_in(1'b0, v);
        chk(v == 8'h00, "R1 register zero after reset", v, 0);
        bus_stop;

        // R3: every address, only 0x50 acknowledged
        for (int a = 0; a < 128; a++) begin
            bus_start;
            byte_out({7'(a), 1'b0}, ack);
            chk(ack == (a == OWN), "R3 address sweep", ack, (a == OWN));
            bus_stop;
        end

        // R2: START in the middle of an address byte restarts reception
        bus_start;
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b1);
        bus_start;
        byte_out({OWN, 1'b0}, ack);
        chk(ack, "R2 restart mid byte", ack, 1);
        bus_stop;

        // R4/R5: write burst across the top of the map
        bus_start;
        byte_out({OWN, 1'b0}, ack);
        byte_out(8'hFE, ack);
        chk(ack, "R4 pointer byte acked", ack, 1);
        byte_out(8'hA5, ack); chk(ack, "R4 data acked", ack, 1);
        byte_out(8'h5A, ack); chk(ack, "R4 data acked", ack, 1);
        byte_out(8'hC3, ack); chk(ack, "R5 data after wrap acked", ack, 1);
        bus_stop;
        exp_mem[8'hFE] = 8'hA5; exp_mem[8'hFF] = 8'h5A; exp_mem[8'h00] = 8'hC3;

        // R6/R5: pointer write, repeated start, read across the wrap
        bus_start;
        byte_out({OWN, 1'b0}, ack);
        byte_out(8'hFE, ack);
        bus_start;
        byte_out({OWN, 1'b1}, ack);
        chk(ack, "R6 read after repeated start acked", ack, 1);
        byte_in(1'b1, v); chk(v == exp_mem[8'hFE], "R6 pointer kept", v, exp_mem[8'hFE]);
        byte_in(1'b1, v); chk(v == exp_mem[8'hFF], "R5 read step", v, exp_mem[8'hFF]);
        byte_in(1'b0, v); chk(v == exp_mem[8'h00], "R5 read wrap", v, exp_mem[8'h00]);
        // R8: after NACK the line stays released for an extra pulse
        bit_in(b);
        chk(b == 1'b1, "R8 released after nack", b, 1);
        bus_stop;

        // R5: pointer carried into the next transfer
        bus_start;
        byte_out({OWN, 1'b1}, ack);
        byte_in(1'b0, v);
        chk(v == exp_mem[8'h01], "R5 pointer persists", v, exp_mem[8'h01]);
        bus_stop;

        // R4: fill the whole map in one burst
        bus_start;
        byte_out({OWN, 1'b0}, ack);
        byte_out(8'h00, ack);
        for (int i = 0; i < 256; i++) begin
            v = 8'((i * 37 + 11) & 255);
            byte_out(v, ack);
            exp_mem[i] = v;
            chk(ack, "R4 burst data acked", ack, 1);
        end
        bus_stop;

        // R6/R8: full read starting mid map
        bus_start;
        byte_out({OWN, 1'b0}, ack);
        byte_out(8'h80, ack);
        bus_start;
        byte_out({OWN, 1'b1}, ack);
        for (int i = 0; i < 256; i++) begin
            byte_in(i != 255, v);
            chk(v == exp_mem[(128 + i) & 255], "R6 burst read", v, exp_mem[(128 + i) & 255]);
        end
        bus_stop;

        // R3: bytes after a foreign address are ignored
        bus_start;
        byte_out({7'h51, 1'b0}, ack);
        chk(!ack, "R3 foreign address", ack, 0);
        byte_out(8'h10, ack);
        chk(!ack, "R3 ignored pointer", ack, 0);
        byte_out(8'hEE, ack);
        chk(!ack, "R3 ignored data", ack, 0);
        bus_stop;
        bus_start;
        byte_out({OWN, 1'b0}, ack);
        byte_out(8'h10, ack);
        bus_start;
        byte_out({OWN, 1'b1}, ack);
        byte_in(1'b0, v);
        chk(v == exp_mem[8'h10], "R3 register untouched", v, exp_mem[8'h10]);
        bus_stop;

        chk(r7_viol == 0, "R7 output moved with SCL high", r7_viol, 0);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected 0 cycles over limit", WD_LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule